// File: doc/BRIEF.md
# Clock Frequency Monitor

This block watches a free-running clock that it does not own and reports when that clock runs too slowly or has stopped. The monitored signal is brought into the reference clock domain through a short synchronizer chain. Its rising edges are then counted over fixed windows of reference cycles. A window that collects fewer edges than a threshold is a failing window, and a failing window puts the monitor into its error state.

The monitor error is active low. It is merged with an active-low watchdog error onto one shared output. When the monitor is armed, which happens on leaving reset or when the enable is raised, the error is asserted at once. It stays asserted as long as windows keep failing. After a passing window a release counter runs for a fixed delay of 16 to 32 reference cycles. The output is released only if no failing window arrives before that count completes.

The defaults assume a 32.768 kHz reference. A 3277-cycle window and a threshold of 10 edges put the decision point near 100 Hz. At that setting a clock at 5 kHz or above yields hundreds of edges per window. A clock below 10 Hz yields at most two edges per window.

Top module: `clk_freq_mon`

## Requirements
- R1: While `rst` is high the monitor contributes no error: `shared_n_o` equals `wdog_n_i`.
- R2: On the first rising edge of `clk` with `rst` low and `mon_en_i` high, the monitor arms and asserts its error. `shared_n_o` is low right after that edge, whatever the monitored input does.
- R3: Windows last `WIN_CYC` reference cycles and are aligned to arming. Window m ends at the (m·`WIN_CYC`)-th edge counted from arming, where the arming edge is number 1. The monitored input passes through `SYNC_STAGES` flops, and each synchronized rising edge is counted. A window passes when its count is at least `MIN_EDGES`.
- R4: A failing window that ends at edge e drives the monitor error from edge e+1. The error is held while windows keep failing. A monitored input stuck low or stuck high is always flagged.
- R5: A passing window that ends at edge e while the error is asserted releases the error right after edge e+1+`REL_CYC`, provided no failing window intervenes. `REL_CYC` is clamped into 16..32 and defaults to 16.
- R6: A failing window that ends during the release delay cancels the release. The error stays asserted, and a fresh passing window is needed to restart the delay.
- R7: Once released, the monitor error stays off for as long as every window passes.
- R8: With `mon_en_i` low the monitor error is removed from the next edge on. The monitored input then has no effect and `shared_n_o` follows `wdog_n_i`.
- R9: Raising `mon_en_i` re-arms the monitor in the same way as R2: the error is asserted after the next edge and window alignment restarts.
- R10: `shared_n_o` is low in any cycle in which `wdog_n_i` is low, independently of the monitor state and without a clock edge.
- R11: With default parameters on a 32.768 kHz reference, a monitored clock of 5 kHz or faster is never flagged once released, and a clock of 10 Hz or slower is always flagged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| mon_clk_i | input | 1 | Monitored clock, asynchronous to `clk` |
| mon_en_i | input | 1 | Monitor enable from the watchdog configuration register |
| wdog_n_i | input | 1 | Active-low watchdog error to be merged |
| shared_n_o | output | 1 | Active-low merged error: low when either source is in error |

## Verification
Two things can land in the same cycle: the release counter reaching its end, and the watchdog input going low. The bench starts a fast clock exactly at a window boundary, so it can compute the edge on which the release falls. It drives `wdog_n_i` low just before that edge and expects the output to stay low across the release, then to rise as soon as the watchdog lets go. A second contest is between a failing window and the running release delay. The bench provokes it with bursts of exactly one window that alternate with gaps of one window, and judges it by the output never rising.

// File: rtl/cfm_pkg.sv
package cfm_pkg;

    localparam int unsigned CFM_REL_LO = 16;
    localparam int unsigned CFM_REL_HI = 32;

    typedef enum logic [1:0] {
        CM_OFF   = 2'd0,
        CM_FAULT = 2'd1,
        CM_HOLD  = 2'd2,
        CM_OK    = 2'd3
    } cm_state_e;

    typedef struct packed {
        logic done;
        logic pass;
    } win_res_t;

    function automatic int unsigned clamp_rel(input int unsigned req);
        if (req < CFM_REL_LO) return CFM_REL_LO;
        if (req > CFM_REL_HI) return CFM_REL_HI;
        return req;
    endfunction

    function automatic logic meets_min(input int unsigned cnt, input logic hit,
                                       input int unsigned min_edges);
        return (cnt + (hit ? 32'd1 : 32'd0)) >= min_edges;
    endfunction

    function automatic logic is_err(input cm_state_e st);
        return (st == CM_FAULT) || (st == CM_HOLD);
    endfunction

endpackage

// File: rtl/cfm_sync.sv
module cfm_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic rise_o
);
    localparam int unsigned NS = (STAGES < 2) ? 2 : STAGES;

    logic [NS-1:0] chain_q;
    logic          prev_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q[0] <= 1'b0;
        else     chain_q[0] <= async_i;
    end

    for (genvar g = 1; g < NS; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain_q[g] <= 1'b0;
            else     chain_q[g] <= chain_q[g-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= chain_q[NS-1];
    end

    assign rise_o = chain_q[NS-1] & ~prev_q;
endmodule

// File: rtl/cfm_window.sv
module cfm_window
    import cfm_pkg::*;
#(
    parameter int unsigned WIN_CYC   = 3277,
    parameter int unsigned MIN_EDGES = 10
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     en_i,
    input  logic     rise_i,
    output win_res_t res_o
);
    localparam int unsigned WB = (WIN_CYC < 2) ? 1 : $clog2(WIN_CYC);
    localparam int unsigned EB = $clog2(MIN_EDGES + 1);
    localparam logic [WB-1:0] WIN_LAST = WB'(WIN_CYC - 1);
    localparam logic [EB-1:0] EDGE_SAT = EB'(MIN_EDGES);

    logic [WB-1:0] win_cnt_q;
    logic [EB-1:0] edge_cnt_q;
    win_res_t      res_q;
    logic          at_end;
    logic          enough;

    assign at_end = (win_cnt_q == WIN_LAST);
    assign enough = meets_min(32'(edge_cnt_q), rise_i, MIN_EDGES);

    always_ff @(posedge clk) begin
        if (rst || !en_i) begin
            win_cnt_q  <= '0;
            edge_cnt_q <= '0;
            res_q      <= '0;
        end else if (at_end) begin
            win_cnt_q  <= '0;
            edge_cnt_q <= '0;
            res_q.done <= 1'b1;
            res_q.pass <= enough;
        end else begin
            win_cnt_q <= win_cnt_q + 1'b1;
            if (rise_i && (edge_cnt_q != EDGE_SAT))
                edge_cnt_q <= edge_cnt_q + 1'b1;
            res_q <= '0;
        end
    end

    assign res_o = res_q;
endmodule

// File: rtl/cfm_release.sv
module cfm_release
    import cfm_pkg::*;
#(
    parameter int unsigned REL_CYC = 16,
    parameter int unsigned RB      = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en_i,
    input  win_res_t      res_i,
    output logic          err_o,
    output cm_state_e     state_o,
    output logic [RB-1:0] rel_cnt_o
);
    localparam logic [RB-1:0] REL_LAST = RB'(REL_CYC - 1);

    cm_state_e     st_q,  st_d;
    logic [RB-1:0] rel_q, rel_d;
    logic          win_fail;
    logic          win_ok;

    assign win_fail = res_i.done & ~res_i.pass;
    assign win_ok   = res_i.done &  res_i.pass;

    always_comb begin
        st_d  = st_q;
        rel_d = rel_q;
        if (!en_i) begin
            st_d  = CM_OFF;
            rel_d = '0;
        end else begin
            unique case (st_q)
                CM_OFF: begin
                    st_d  = CM_FAULT;
                    rel_d = '0;
                end
                CM_FAULT: begin
                    if (win_ok) begin
                        st_d  = CM_HOLD;
                        rel_d = '0;
                    end
                end
                CM_HOLD: begin
                    if (win_fail) begin
                        st_d  = CM_FAULT;
                        rel_d = '0;
                    end else if (rel_q == REL_LAST) begin
                        st_d  = CM_OK;
                        rel_d = '0;
                    end else begin
                        rel_d = rel_q + 1'b1;
                    end
                end
                CM_OK: begin
                    if (win_fail) st_d = CM_FAULT;
                end
                default: st_d = CM_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= CM_OFF;
            rel_q <= '0;
        end else begin
            st_q  <= st_d;
            rel_q <= rel_d;
        end
    end

    assign err_o     = is_err(st_q);
    assign state_o   = st_q;
    assign rel_cnt_o = rel_q;
endmodule

// File: rtl/clk_freq_mon.sv
module clk_freq_mon
    import cfm_pkg::*;
#(
    parameter int unsigned WIN_CYC     = 3277,
    parameter int unsigned MIN_EDGES   = 10,
    parameter int unsigned REL_CYC     = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic mon_clk_i,
    input  logic mon_en_i,
    input  logic wdog_n_i,
    output logic shared_n_o
);
    localparam int unsigned REL_EFF = clamp_rel(REL_CYC);
    localparam int unsigned RB      = $clog2(REL_EFF);

    logic          mon_rise;
    win_res_t      win_res;
    logic          cm_err;
    cm_state_e     cm_state;
    logic [RB-1:0] rel_cnt;

    cfm_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (mon_clk_i),
        .rise_o  (mon_rise)
    );

    cfm_window #(
        .WIN_CYC   (WIN_CYC),
        .MIN_EDGES (MIN_EDGES)
    ) u_win (
        .clk    (clk),
        .rst    (rst),
        .en_i   (mon_en_i),
        .rise_i (mon_rise),
        .res_o  (win_res)
    );

    cfm_release #(
        .REL_CYC (REL_EFF),
        .RB      (RB)
    ) u_rel (
        .clk       (clk),
        .rst       (rst),
        .en_i      (mon_en_i),
        .res_i     (win_res),
        .err_o     (cm_err),
        .state_o   (cm_state),
        .rel_cnt_o (rel_cnt)
    );

    assign shared_n_o = wdog_n_i & ~cm_err;
endmodule

// File: rtl/cfm_chk.sv
module cfm_chk
    import cfm_pkg::*;
#(
    parameter int unsigned REL_CYC = 16,
    parameter int unsigned RB      = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          en,
    input logic          wdog_n,
    input logic          shared_n,
    input logic          win_done,
    input logic          win_pass,
    input logic          cm_err,
    input cm_state_e     state,
    input logic [RB-1:0] rel_cnt
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        (rst && $past(rst)) |-> (shared_n == wdog_n));

    // R2
    arm_raises_chk: assert property (@(posedge clk) disable iff (rst)
        (state == CM_OFF && en) |=> cm_err);

    // R4
    fail_window_chk: assert property (@(posedge clk) disable iff (rst)
        (en && win_done && !win_pass) |=> cm_err);

    // R5
    release_delay_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(cm_err) && $past(en)) |->
            ($past(state) == CM_HOLD && $past(rel_cnt) == RB'(REL_CYC - 1)));

    // R6
    hold_cancel_chk: assert property (@(posedge clk) disable iff (rst)
        (en && state == CM_HOLD && win_done && !win_pass) |=> (state == CM_FAULT));

    // R7
    stay_ok_chk: assert property (@(posedge clk) disable iff (rst)
        (en && state == CM_OK && !(win_done && !win_pass)) |=> !cm_err);

    // R8
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> !cm_err);

    // R10
    wdog_merge_chk: assert property (@(posedge clk) disable iff (rst)
        !wdog_n |-> !shared_n);
endmodule

bind clk_freq_mon cfm_chk #(
    .REL_CYC (REL_EFF),
    .RB      (RB)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .en       (mon_en_i),
    .wdog_n   (wdog_n_i),
    .shared_n (shared_n_o),
    .win_done (win_res.done),
    .win_pass (win_res.pass),
    .cm_err   (cm_err),
    .state    (cm_state),
    .rel_cnt  (rel_cnt)
);

// File: tb/clk_freq_mon_bench.sv
module clk_freq_mon_bench;
    localparam int W   = 12;
    localparam int M   = 3;
    localparam int REL = 16;
    localparam int DW  = 3277;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst = 1'b1, en = 1'b1, wd_n = 1'b1, mon = 1'b0, mon_d = 1'b0;
    logic sh_n, sh_d_n;

    int g_mode = 0, g_per = 2, per_d = 0, kcnt = 0;
    bit g_sync = 1'b0;
    int n_chk = 0, n_fail = 0;
    bit done_flag = 1'b0;

    clk_freq_mon #(.WIN_CYC(W), .MIN_EDGES(M), .REL_CYC(REL), .SYNC_STAGES(2)) u_clk_freq_mon (
        .clk(clk), .rst(rst), .mon_clk_i(mon), .mon_en_i(en),
        .wdog_n_i(wd_n), .shared_n_o(sh_n));

    clk_freq_mon u_clk_freq_mon_dflt (
        .clk(clk), .rst(rst), .mon_clk_i(mon_d), .mon_en_i(1'b1),
        .wdog_n_i(1'b1), .shared_n_o(sh_d_n));

    initial begin : gen_main
        int ph;
        bit last;
        ph = 0;
        last = 1'b0;
        forever begin
            @(negedge clk);
            if (g_sync != last) begin ph = 0; last = g_sync; end
            case (g_mode)
                0: mon = 1'b0;
                1: mon = 1'b1;
                default: begin
                    mon = (ph < g_per / 2);
                    ph = (ph + 1 >= g_per) ? 0 : ph + 1;
                end
            endcase
        end
    end

    initial begin : gen_dflt
        int ph;
        ph = 0;
        forever begin
            @(negedge clk);
            if (per_d == 0) mon_d = 1'b0;
            else begin
                mon_d = (ph < per_d / 2);
                ph = (ph + 1 >= per_d) ? 0 : ph + 1;
            end
        end
    end

    initial forever begin
        @(posedge clk);
        if (!rst) kcnt++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic after_edge();
        @(posedge clk);
        #1;
    endtask

    task automatic set_gen(input int mode, input int per);
        after_edge();
        g_mode = mode;
        g_per  = per;
        g_sync = ~g_sync;
    endtask

    task automatic align();
        do after_edge(); while (kcnt % W != 0);
    endtask

    task automatic count_low(input int n, output int lows);
        lows = 0;
        repeat (n) begin
            @(negedge clk);
            if (!sh_n) lows++;
        end
    endtask

    task automatic count_low_d(input int n, output int lows);
        lows = 0;
        repeat (n) begin
            @(negedge clk);
            if (!sh_d_n) lows++;
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : main
        int lows, k0, rel_k, exp_l;
        repeat (3) @(negedge clk);
        chk(sh_n == 1'b1, "R1 reset wd high", sh_n, 1);
        wd_n = 1'b0;
        @(negedge clk);
        chk(sh_n == 1'b0, "R1/R10 reset wd low", sh_n, 0);
        wd_n = 1'b1;
        @(negedge clk);
        chk(sh_n == 1'b1, "R1 reset wd released", sh_n, 1);
        rst = 1'b0;
        @(negedge clk);
        chk(sh_n == 1'b0 && kcnt == 1, "R2 armed at once", {kcnt[7:0], 7'd0, sh_n}, 256);

        // R4: stuck-low clock held in error
        count_low(3 * W, lows);
        chk(lows == 3 * W, "R4 stuck low", lows, 3 * W);

        // R3/R4/R7 sweep of monitored periods
        for (int p = 2; p <= 16; p++) begin
            int fl, ce;
            fl = W / p;
            ce = (W + p - 1) / p;
            if (fl >= M || ce < M) begin
                set_gen(2, p);
                repeat (5 * W + REL + 8) @(negedge clk);
                count_low(3 * W, lows);
                exp_l = (fl >= M) ? 0 : 3 * W;
                chk(lows == exp_l, (fl >= M) ? "R3/R7 fast period" : "R3/R4 slow period",
                    lows, exp_l);
            end
        end

        // R4: stuck-high clock
        set_gen(1, 2);
        repeat (3 * W) @(negedge clk);
        count_low(3 * W, lows);
        chk(lows == 3 * W, "R4 stuck high", lows, 3 * W);

        // R5: exact release edge
        set_gen(0, 2);
        repeat (3 * W) @(negedge clk);
        align();
        k0 = kcnt;
        g_mode = 2; g_per = 2; g_sync = ~g_sync;
        rel_k = -1;
        for (int i = 0; i < 200 && rel_k < 0; i++) begin
            @(negedge clk);
            if (sh_n) rel_k = kcnt;
        end
        chk(rel_k == k0 + W + 1 + REL, "R5 release edge", rel_k, k0 + W + 1 + REL);

        // R6: alternating one-window bursts never release
        set_gen(0, 2);
        repeat (3 * W) @(negedge clk);
        lows = 0;
        align();
        for (int b = 0; b < 6; b++) begin
            g_mode = 2; g_per = 2; g_sync = ~g_sync;
            repeat (W) begin after_edge(); if (sh_n) lows++; end
            g_mode = 0;
            repeat (W) begin after_edge(); if (sh_n) lows++; end
        end
        chk(lows == 0, "R6 hold cancelled", lows, 0);

        // R10 with R5 in the same cycle
        repeat (3 * W) @(negedge clk);
        align();
        k0 = kcnt;
        g_mode = 2; g_per = 2; g_sync = ~g_sync;
        while (kcnt < k0 + W + REL) after_edge();
        wd_n = 1'b0;
        count_low(4, lows);
        chk(lows == 4, "R10 wd low across release", lows, 4);
        wd_n = 1'b1;
        #1;
        chk(sh_n == 1'b1, "R5 released after wd", sh_n, 1);

        // R8: disable ignores stopped clock
        set_gen(0, 2);
        @(negedge clk);
        en = 1'b0;
        repeat (5 * W) @(negedge clk);
        count_low(3 * W, lows);
        chk(lows == 0, "R8 disabled quiet", lows, 0);
        wd_n = 1'b0;
        #1;
        chk(sh_n == 1'b0, "R8/R10 follows wd", sh_n, 0);
        @(negedge clk);
        wd_n = 1'b1;

        // R9: re-arm
        @(negedge clk);
        en = 1'b1;
        @(negedge clk);
        chk(sh_n == 1'b0, "R9 re-armed", sh_n, 0);
        set_gen(2, 2);
        repeat (2 * W + REL + 6) @(negedge clk);
        chk(sh_n == 1'b1, "R9 released after re-arm", sh_n, 1);

        // R11: default configuration
        after_edge();
        per_d = 6;
        repeat (3 * DW + 100) @(negedge clk);
        count_low_d(DW, lows);
        chk(lows == 0, "R11 5 kHz not flagged", lows, 0);
        after_edge();
        per_d = 3276;
        repeat (2 * DW + 100) @(negedge clk);
        count_low_d(DW, lows);
        chk(lows == DW, "R11 10 Hz flagged", lows, DW);

        done_flag = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule